// File: doc/BRIEF.md
# 8x8 Inverse DCT Engine

This block turns one 8x8 block of dequantised frequency coefficients back into 64 greyscale pixels. It sits at the end of an image decode chain. It pulls coefficients from the stage above with a request line and accepts one coefficient per cycle while that request is high. Once all 64 coefficients of a block are held, the block runs the separable two-dimensional inverse cosine transform. It restores the mid-grey offset of 128 and saturates each result to an 8-bit pixel.

The transform is computed as two one-dimensional passes through a single multiply-accumulate unit. The first pass works along each coefficient row and writes an intermediate array. The second pass works down the columns of that array and produces finished pixels in row-major order. Two input banks let the next block load while the current one is transformed. The request falls only when both banks are occupied.

Top module: `idct8_engine`

## Requirements
- R1: After reset, coef_req is 1 and pix_valid is 0.
- R2: A coefficient is stored when coef_valid and coef_req are both 1 at a rising edge. The 64 stored values of a block are taken in raster order: index 8*v+u holds S(v,u), where v is the vertical frequency and u is the horizontal frequency. The 64th value completes the block.
- R3: The cosine weights are Q12 signed integers. For frequency n>0, the weight at position p is K(p,n) = round(4096*cos((2p+1)*n*pi/16)), rounded to nearest with ties away from zero. K(p,0) is 2896, which is 4096/sqrt(2) rounded.
- R4: The row pass forms T(v,x) = floor((sum over u of S(v,u)*K(x,u) + 2048) / 4096).
- R5: Each pixel is p(y,x) = floor((sum over v of T(v,x)*K(y,v) + 8192) / 16384) + 128, saturated to the range 0..255 and driven on pix_data.
- R6: Each block yields exactly 64 pixels in row-major order (y outer, x inner). Each pixel is marked by a one-cycle pix_valid, and pix_valid is never high in two consecutive cycles.
- R7: coef_req stays 1 while at most one bank holds an unprocessed or in-process block. It is 0 while both banks hold blocks.
- R8: The bank that feeds the row pass is freed when that pass completes, so a low coef_req returns to 1 without waiting for the column pass.
- R9: coef_valid pulses while coef_req is 0 are ignored. They neither store data nor advance the write position.
- R10: A transform starts only after a whole block is held. No pixel appears during the row pass, so the first pixel of a block follows its last coefficient by at least 520 cycles.
- R11: Blocks are transformed and emitted in the order in which they were loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| coef_data | input | COEF_W (12) | Signed dequantised coefficient |
| coef_valid | input | 1 | coef_data holds a coefficient |
| coef_req | output | 1 | Block can accept a coefficient this cycle |
| pix_data | output | 8 | Reconstructed pixel value |
| pix_valid | output | 1 | One-cycle strobe marking a pixel on pix_data |

## Verification
The hardest state to reach from the ports has one block in the row pass and a second block fully loaded behind it, so the request is low. In that state the upstream side keeps asserting valid with unrelated data. The stimulus reaches it by sending two blocks back to back into an idle engine and then driving valid with random values for forty cycles. It then waits for the request to return and sends a further block whose pixels expose any stray write. Saturation at both ends and the ordering of single horizontal and vertical frequency terms are covered with hand-built blocks, and pseudo-random blocks cover the rest.

// File: rtl/idct_pkg.sv
package idct_pkg;
  localparam int N       = 8;
  localparam int CONST_W = 14;
  localparam int FRAC    = 12;

  typedef enum logic [1:0] {PH_IDLE, PH_ROW, PH_COL} phase_e;

  // Q12 cosine magnitudes for angle index m (m*pi/16), m in 0..8
  function automatic logic signed [CONST_W-1:0] cos_mag(input int m);
    case (m)
      0: return 14'sd4096;
      1: return 14'sd4017;
      2: return 14'sd3784;
      3: return 14'sd3406;
      4: return 14'sd2896;
      5: return 14'sd2276;
      6: return 14'sd1567;
      7: return 14'sd799;
      default: return 14'sd0;
    endcase
  endfunction

  // Weight for position pos and frequency freq, including the DC normalisation
  function automatic logic signed [CONST_W-1:0] basis(input logic [2:0] pos,
                                                      input logic [2:0] freq);
    int m;
    if (freq == 3'd0) return 14'sd2896;
    m = ((2 * int'(pos) + 1) * int'(freq)) % 32;
    if (m > 16) m = 32 - m;
    if (m > 8) return -cos_mag(16 - m);
    return cos_mag(m);
  endfunction
endpackage

// File: rtl/idct_inbuf.sv
module idct_inbuf #(
  parameter int COEF_W = 12,
  parameter int BLK    = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [COEF_W-1:0] wr_data,
  input  logic                     wr_valid,
  output logic                     wr_req,
  output logic                     blk_loaded,
  input  logic [$clog2(BLK)-1:0]   rd_addr,
  output logic signed [COEF_W-1:0] rd_data,
  output logic                     blk_ready,
  input  logic                     blk_release,
  output logic [1:0]               occ
);
  localparam int AW = $clog2(BLK);

  logic signed [COEF_W-1:0] mem [2][BLK];
  logic [1:0]    full;
  logic          wr_bank;
  logic          rd_bank;
  logic [AW-1:0] wr_cnt;
  logic          wr_accept;

  assign wr_req     = !full[wr_bank];
  assign wr_accept  = wr_valid && wr_req;
  assign blk_loaded = wr_accept && (wr_cnt == AW'(BLK - 1));
  assign blk_ready  = full[rd_bank];
  assign rd_data    = mem[rd_bank][rd_addr];
  assign occ        = {1'b0, full[0]} + {1'b0, full[1]};

  always_ff @(posedge clk) begin
    if (wr_accept) mem[wr_bank][wr_cnt] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full    <= '0;
      wr_bank <= 1'b0;
      rd_bank <= 1'b0;
      wr_cnt  <= '0;
    end else begin
      if (wr_accept) wr_cnt <= blk_loaded ? '0 : wr_cnt + 1'b1;
      if (blk_loaded) begin
        full[wr_bank] <= 1'b1;
        wr_bank       <= ~wr_bank;
      end
      if (blk_release) begin
        full[rd_bank] <= 1'b0;
        rd_bank       <= ~rd_bank;
      end
    end
  end
endmodule

// File: rtl/idct_mac_core.sv
module idct_mac_core
  import idct_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     blk_ready,
  output logic [2*$clog2(N)-1:0]   rd_addr,
  input  logic signed [COEF_W-1:0] rd_data,
  output logic                     blk_release,
  output phase_e                   phase,
  output logic [7:0]               pix_out,
  output logic                     pix_valid
);
  localparam int KW    = $clog2(N);
  localparam int AW    = 2 * KW;
  localparam int BLK   = N * N;
  localparam int TW    = COEF_W + 4;
  localparam int PW    = TW + CONST_W;
  localparam int ACC_W = PW + KW;
  localparam logic signed [ACC_W-1:0] HALF_ROW = ACC_W'(1) << (FRAC - 1);
  localparam logic signed [ACC_W-1:0] HALF_COL = ACC_W'(1) << (FRAC + 1);

  logic [AW-1:0]            outer;
  logic [KW-1:0]            k;
  logic signed [ACC_W-1:0]  acc;
  logic signed [TW-1:0]     tbuf [BLK];
  logic [KW-1:0]            hi;
  logic [KW-1:0]            lo;
  logic signed [TW-1:0]     opnd;
  logic signed [CONST_W-1:0] wgt;
  logic signed [PW-1:0]     prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_sum;
  logic                     last_tap;
  logic                     last_out;

  function automatic logic signed [TW-1:0] row_round(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = a + HALF_ROW;
    r = r >>> FRAC;
    return r[TW-1:0];
  endfunction

  function automatic logic [7:0] to_pixel(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W-1:0] r;
    r = a + HALF_COL;
    r = r >>> (FRAC + 2);
    r = r + ACC_W'(128);
    if (r < 0) return 8'd0;
    if (r > 255) return 8'd255;
    return r[7:0];
  endfunction

  assign hi       = outer[AW-1:KW];
  assign lo       = outer[KW-1:0];
  assign rd_addr  = {hi, k};
  assign opnd     = (phase == PH_ROW) ? {{(TW-COEF_W){rd_data[COEF_W-1]}}, rd_data}
                                      : tbuf[{k, lo}];
  assign wgt      = (phase == PH_ROW) ? basis(lo, k) : basis(hi, k);
  assign prod     = opnd * wgt;
  assign prod_ext = {{KW{prod[PW-1]}}, prod};
  assign acc_sum  = acc + prod_ext;
  assign last_tap = (k == KW'(N - 1));
  assign last_out = (outer == AW'(BLK - 1));
  assign blk_release = (phase == PH_ROW) && last_tap && last_out;

  always_ff @(posedge clk) begin
    if (phase == PH_ROW && last_tap) tbuf[outer] <= row_round(acc_sum);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      outer     <= '0;
      k         <= '0;
      acc       <= '0;
      pix_out   <= '0;
      pix_valid <= 1'b0;
    end else begin
      pix_valid <= (phase == PH_COL) && last_tap;
      if (phase == PH_COL && last_tap) pix_out <= to_pixel(acc_sum);
      case (phase)
        PH_IDLE: begin
          outer <= '0;
          k     <= '0;
          acc   <= '0;
          if (blk_ready) phase <= PH_ROW;
        end
        default: begin
          k   <= k + 1'b1;
          acc <= last_tap ? '0 : acc_sum;
          if (last_tap) begin
            outer <= outer + 1'b1;
            if (last_out) phase <= (phase == PH_ROW) ? PH_COL : PH_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/idct8_engine.sv
module idct8_engine
  import idct_pkg::*;
#(
  parameter int COEF_W = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [COEF_W-1:0] coef_data,
  input  logic                     coef_valid,
  output logic                     coef_req,
  output logic [7:0]               pix_data,
  output logic                     pix_valid
);
  localparam int BLK = N * N;
  localparam int AW  = $clog2(BLK);

  logic [AW-1:0]            rd_addr;
  logic signed [COEF_W-1:0] rd_data;
  logic                     blk_ready;
  logic                     blk_release;
  logic                     blk_loaded;
  logic [1:0]               buf_occ;
  phase_e                   core_phase;

  idct_inbuf #(.COEF_W(COEF_W), .BLK(BLK)) inbuf_i (
    .clk(clk), .rst_n(rst_n),
    .wr_data(coef_data), .wr_valid(coef_valid), .wr_req(coef_req),
    .blk_loaded(blk_loaded),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .blk_ready(blk_ready), .blk_release(blk_release), .occ(buf_occ)
  );

  idct_mac_core #(.COEF_W(COEF_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .blk_ready(blk_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .blk_release(blk_release), .phase(core_phase),
    .pix_out(pix_data), .pix_valid(pix_valid)
  );
endmodule

// File: rtl/idct8_engine_chk.sv
module idct8_engine_chk
  import idct_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic       coef_req,
  input logic       pix_valid,
  input logic [1:0] occ,
  input logic       blk_loaded,
  input logic       blk_release,
  input logic       blk_ready,
  input phase_e     phase
);
  AST_REQ_WITH_FREE_BANK: assert property (@(posedge clk) disable iff (!rst_n) (occ == 2'd0) |-> coef_req); // R7
  AST_REQ_LOW_BOTH_HELD: assert property (@(posedge clk) disable iff (!rst_n) (occ == 2'd2) |-> !coef_req); // R7
  AST_LOAD_FILLS_BANK: assert property (@(posedge clk) disable iff (!rst_n) (blk_loaded && !blk_release) |=> (occ == $past(occ) + 2'd1)); // R2
  AST_ROW_PASS_SILENT: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_ROW) |-> !pix_valid); // R10
  AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) pix_valid |=> !pix_valid); // R6
  AST_RELEASE_AT_ROW_END: assert property (@(posedge clk) disable iff (!rst_n) blk_release |=> (phase == PH_COL)); // R8
  AST_START_ON_FULL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (phase == PH_IDLE && blk_ready) |=> (phase == PH_ROW)); // R10
endmodule

bind idct8_engine idct8_engine_chk chk_i (
  .clk(clk), .rst_n(rst_n), .coef_req(coef_req), .pix_valid(pix_valid),
  .occ(buf_occ), .blk_loaded(blk_loaded), .blk_release(blk_release),
  .blk_ready(blk_ready), .phase(core_phase)
);

// File: tb/idct8_engine_tb_top.sv
module idct8_engine_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int COEF_W     = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed [COEF_W-1:0] coef_data = '0;
  logic coef_valid = 1'b0;
  logic coef_req;
  logic [7:0] pix_data;
  logic pix_valid;

  int checks = 0;
  int errors = 0;
  int exp_q[$];
  string tag_q[$];
  int pix_seen = 0;
  int pix_expected = 0;
  logic prev_valid = 1'b0;
  logic [31:0] lcg = 32'h1234_5678;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  idct8_engine #(.COEF_W(COEF_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .coef_data(coef_data), .coef_valid(coef_valid),
    .coef_req(coef_req), .pix_data(pix_data), .pix_valid(pix_valid)
  );

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // R3 weights from real cosines
  function automatic int kq(input int p, input int n);
    real r;
    if (n == 0) r = 4096.0 / $sqrt(2.0);
    else r = 4096.0 * $cos(real'((2*p+1)*n) * 3.14159265358979 / 16.0);
    if (r >= 0.0) return $rtoi(r + 0.5);
    return -$rtoi(-r + 0.5);
  endfunction

  // R4 / R5 restated on whole-number arithmetic
  function automatic void model_block(input int s[64], output int px[64]);
    longint t[64];
    for (int v = 0; v < 8; v++)
      for (int x = 0; x < 8; x++) begin
        longint acc = 0;
        for (int u = 0; u < 8; u++) acc += longint'(s[v*8+u]) * kq(x, u);
        t[v*8+x] = (acc + 2048) >>> 12;
      end
    for (int y = 0; y < 8; y++)
      for (int x = 0; x < 8; x++) begin
        longint acc = 0;
        longint p;
        for (int v = 0; v < 8; v++) acc += t[v*8+x] * kq(y, v);
        p = ((acc + 8192) >>> 14) + 128;
        if (p < 0) p = 0;
        if (p > 255) p = 255;
        px[y*8+x] = int'(p);
      end
  endfunction

  function automatic int rnd(input int span);
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return int'(lcg[27:16] % span) - span / 2;
  endfunction

  task automatic send_block(input int s[64], input string tag);
    int px[64];
    int i = 0;
    model_block(s, px);
    for (int j = 0; j < 64; j++) begin
      exp_q.push_back(px[j]);
      tag_q.push_back(tag);
    end
    pix_expected += 64;
    while (i < 64) begin
      @(posedge clk); #1;
      coef_valid = 1'b1;
      coef_data  = COEF_W'(s[i]);
      @(negedge clk);
      if (coef_req) i++;
    end
    @(posedge clk); #1;
    coef_valid = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while (exp_q.size() != 0 && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  // Pixel monitor: compares every strobe against the reference queue (R6, R11)
  always @(negedge clk) begin
    if (rst_n) begin
      if (pix_valid) begin
        pix_seen++;
        if (exp_q.size() == 0) check("R6", 1, 0, "pixel with none expected");
        else check(tag_q.pop_front(), int'(pix_data), exp_q.pop_front(), "pixel value (R11 order)");
      end
      if (pix_valid && prev_valid) check("R6", 1, 0, "strobe in consecutive cycles");
      prev_valid = pix_valid;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    int blk[64];
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(coef_req), 1, "coef_req after reset");
    check("R1", int'(pix_valid), 0, "pix_valid after reset");

    // Zero block: all mid-grey; measure latency (R10)
    foreach (blk[j]) blk[j] = 0;
    send_block(blk, "R5");
    n = 0;
    while (!pix_valid && n < 3000) begin @(negedge clk); n++; end
    check("R10", int'(n >= 520), 1, "first pixel latency at least 520");
    drain();

    // DC only, then back-to-back block with a single horizontal term
    foreach (blk[j]) blk[j] = 0;
    blk[0] = 800;
    send_block(blk, "R4");
    @(negedge clk);
    check("R7", int'(coef_req), 1, "request with one bank held");
    foreach (blk[j]) blk[j] = 0;
    blk[1] = 400;
    send_block(blk, "R2");
    @(negedge clk);
    check("R7", int'(coef_req), 0, "request with both banks held");

    // Garbage while request is low (R9)
    for (int g = 0; g < 40; g++) begin
      @(posedge clk); #1;
      coef_valid = 1'b1;
      coef_data  = COEF_W'(rnd(4096));
    end
    @(posedge clk); #1;
    coef_valid = 1'b0;
    n = 0;
    while (!coef_req && n < 600) begin @(negedge clk); n++; end
    check("R8", int'(coef_req), 1, "request back once row pass ends");

    // Single vertical term plus others; reveals any stray write
    foreach (blk[j]) blk[j] = 0;
    blk[8] = -500;
    blk[9] = 120;
    blk[0] = -96;
    send_block(blk, "R9");

    // Saturation high and low
    foreach (blk[j]) blk[j] = 0;
    blk[0] = 2047;
    send_block(blk, "R5");
    foreach (blk[j]) blk[j] = 0;
    blk[0] = -2048;
    send_block(blk, "R5");

    // Pseudo-random blocks
    foreach (blk[j]) blk[j] = rnd(4096);
    send_block(blk, "R3");
    for (int b = 0; b < 3; b++) begin
      foreach (blk[j]) blk[j] = rnd(256);
      send_block(blk, "R11");
    end
    drain();
    repeat (20) @(negedge clk);
    check("R6", pix_seen, pix_expected, "total pixel count");
    check("R6", exp_q.size(), 0, "pixels left unreceived");
    done = 1'b1;
    finish_run();
  end
endmodule